// File: doc/BRIEF.md
# Edge-Triggered Force Flip-Flop Bank

This block holds a small bank of independent storage bits. Every bit has its own data line, capture strobe, force-high line and force-low line, and it drives a true output and its complement. A rising edge on the capture strobe loads the data into the bit. The force lines act only on their rising transitions. A force line that stays high after its edge does not block later captures, so a bit can be forced and then loaded again without first releasing the force.

All inputs are treated as asynchronous to one fast system clock. Each input passes through a two-stage synchronizer. Rising edges are found by comparing the synchronized sample with the sample taken one cycle earlier. After each accepted force, a recovery window of `RECOVERY_CYCLES` system-clock cycles follows. During that window, any capture or force edge on that bit is discarded. The window is set per instance as a parameter.

Top module: `trig_ff_bank`

## Requirements
- R1: The channels are independent. Bit i of every input vector and output vector belongs to channel i, and activity on one channel never changes another channel's output.
- R2: A rising edge on `cap_in[i]` with no force edge in the same cycle loads `d_in[i]` into `q[i]`. A change on an input sampled at one rising edge of `clk` appears on `q` two rising edges later.
- R3: A rising edge on `clr_in[i]` drives `q[i]` low, whatever the data and capture inputs are doing.
- R4: A rising edge on `set_in[i]` drives `q[i]` high, whatever the data and capture inputs are doing.
- R5: A force line held high after its edge has no further effect. The next capture edge loads data normally.
- R6: `q_n[i]` is always the inverse of `q[i]`.
- R7: After an accepted force edge, any capture, set or clear edge on that channel detected within the next `RECOVERY_CYCLES` system-clock cycles is dropped, not deferred. An edge detected `RECOVERY_CYCLES`+1 cycles later acts.
- R8: If set and clear edges are detected in the same cycle, clear wins and the output goes low.
- R9: A force edge takes priority over a capture edge detected in the same cycle.
- R10: A synchronous active-high `rst` drives all outputs low and clears all edge history and recovery state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| d_in | input | CHANNELS | Data input per channel |
| cap_in | input | CHANNELS | Capture strobe per channel; acts on its rising edge |
| set_in | input | CHANNELS | Force-high line per channel; acts on its rising edge |
| clr_in | input | CHANNELS | Force-low line per channel; acts on its rising edge |
| q | output | CHANNELS | Stored bit per channel |
| q_n | output | CHANNELS | Complement of `q` |

## Verification
The assertions assume that every input holds each level for at least one full system-clock cycle, so that the synchronizer catches every transition. They also assume that data is stable while the matching capture edge moves through the synchronizer. The bench changes inputs only on falling edges of `clk`, and it never changes data in the same cycle as that channel's capture rise. It also keeps at least one cycle between a line's fall and its next rise. The bench places edges exactly `RECOVERY_CYCLES` and `RECOVERY_CYCLES`+1 cycles after a force, which tests both sides of the window boundary.

// File: rtl/trig_ff_bank.sv
module trig_ff_bank #(
  parameter int CHANNELS        = 3,
  parameter int RECOVERY_CYCLES = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [CHANNELS-1:0] d_in,
  input  logic [CHANNELS-1:0] cap_in,
  input  logic [CHANNELS-1:0] set_in,
  input  logic [CHANNELS-1:0] clr_in,
  output logic [CHANNELS-1:0] q,
  output logic [CHANNELS-1:0] q_n
);
  localparam int CW = $clog2(RECOVERY_CYCLES + 2);
  localparam logic [CW-1:0] WINDOW = CW'(RECOVERY_CYCLES);

  logic [CHANNELS-1:0] d_s, cap_hit, set_hit, clr_hit, idle;

  for (genvar i = 0; i < CHANNELS; i++) begin : g_ch
    logic [3:0]    s1, s2;
    logic [2:0]    prev;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
      if (rst) begin
        s1   <= '0;
        s2   <= '0;
        prev <= '0;
      end else begin
        s1   <= {clr_in[i], set_in[i], cap_in[i], d_in[i]};
        s2   <= s1;
        prev <= s2[3:1];
      end
    end

    assign d_s[i]     = s2[0];
    assign cap_hit[i] = s2[1] & ~prev[0];
    assign set_hit[i] = s2[2] & ~prev[1];
    assign clr_hit[i] = s2[3] & ~prev[2];
    assign idle[i]    = (cnt == '0);

    always_ff @(posedge clk) begin
      if (rst) begin
        q[i] <= 1'b0;
        cnt  <= '0;
      end else if (!idle[i]) begin
        cnt  <= cnt - CW'(1);
      end else if (clr_hit[i]) begin
        q[i] <= 1'b0;
        cnt  <= WINDOW;
      end else if (set_hit[i]) begin
        q[i] <= 1'b1;
        cnt  <= WINDOW;
      end else if (cap_hit[i]) begin
        q[i] <= d_s[i];
      end
    end
  end

  assign q_n = ~q;
endmodule

// File: rtl/trig_ff_bank_chk.sv
module trig_ff_bank_chk #(
  parameter int CHANNELS = 3
) (
  input logic                clk,
  input logic                rst,
  input logic [CHANNELS-1:0] d_s,
  input logic [CHANNELS-1:0] cap_hit,
  input logic [CHANNELS-1:0] set_hit,
  input logic [CHANNELS-1:0] clr_hit,
  input logic [CHANNELS-1:0] idle,
  input logic [CHANNELS-1:0] q
);
  for (genvar i = 0; i < CHANNELS; i++) begin : g_a
    assert_clear_low_R3: assert property (@(posedge clk) disable iff (rst)
      (idle[i] && clr_hit[i]) |=> !q[i]);
    assert_set_high_R4: assert property (@(posedge clk) disable iff (rst)
      (idle[i] && set_hit[i] && !clr_hit[i]) |=> q[i]);
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
      (idle[i] && cap_hit[i] && !set_hit[i] && !clr_hit[i]) |=> (q[i] == $past(d_s[i])));
    assert_window_hold_R7: assert property (@(posedge clk) disable iff (rst)
      !idle[i] |=> $stable(q[i]));
    assert_quiet_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (!cap_hit[i] && !set_hit[i] && !clr_hit[i]) |=> $stable(q[i]));
  end
  assert_reset_low_R10: assert property (@(posedge clk) rst |=> (q == '0));
endmodule

bind trig_ff_bank trig_ff_bank_chk #(.CHANNELS(CHANNELS)) u_chk (
  .clk(clk), .rst(rst), .d_s(d_s), .cap_hit(cap_hit), .set_hit(set_hit),
  .clr_hit(clr_hit), .idle(idle), .q(q)
);

// File: tb/tb_trig_ff_bank.sv
module tb_trig_ff_bank;
  localparam int CLK_PERIOD = 10;
  localparam int CH  = 3;
  localparam int REC = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [CH-1:0] d_in = '0, cap_in = '0, set_in = '0, clr_in = '0;
  logic [CH-1:0] q, q_n;
  logic [CH-1:0] exp_q = '0;
  int checks = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  trig_ff_bank #(.CHANNELS(CH), .RECOVERY_CYCLES(REC)) dut (
    .clk(clk), .rst(rst), .d_in(d_in), .cap_in(cap_in), .set_in(set_in),
    .clr_in(clr_in), .q(q), .q_n(q_n)
  );

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_all(input string tag);
    for (int i = 0; i < CH; i++) begin
      checks++;
      if (q[i] !== exp_q[i] || q_n[i] !== ~exp_q[i]) begin
        fails++;
        $display("FAIL %s ch%0d: q=%b q_n=%b expected q=%b q_n=%b",
                 tag, i, q[i], q_n[i], exp_q[i], ~exp_q[i]);
      end
    end
  endtask

  task automatic settle();
    cyc(REC + 6);
  endtask

  task automatic capture(input int ch, input logic v);
    d_in[ch] = v; cyc(1);
    cap_in[ch] = 1'b1; cyc(3);
    cap_in[ch] = 1'b0; cyc(2);
  endtask

  task automatic t_reset_state();
    check_all("R10 reset state");
  endtask

  task automatic t_capture();
    capture(0, 1'b1); exp_q[0] = 1'b1; check_all("R2 capture one, R1 others");
    capture(2, 1'b1); exp_q[2] = 1'b1; check_all("R2 capture ch2, R6 complement");
    capture(0, 1'b0); exp_q[0] = 1'b0; check_all("R2 capture zero");
    capture(2, 1'b0); exp_q[2] = 1'b0; check_all("R1 ch2 back low");
  endtask

  task automatic t_set_held();
    set_in[1] = 1'b1; cyc(3); exp_q[1] = 1'b1; check_all("R4 set edge");
    settle();
    capture(1, 1'b0); exp_q[1] = 1'b0; check_all("R5 capture with set held");
    capture(1, 1'b1); exp_q[1] = 1'b1; check_all("R5 second capture with set held");
    set_in[1] = 1'b0; cyc(2);
  endtask

  task automatic t_clear_held();
    d_in[1] = 1'b1; cyc(1);
    clr_in[1] = 1'b1; cyc(3); exp_q[1] = 1'b0; check_all("R3 clear edge");
    settle();
    capture(1, 1'b1); exp_q[1] = 1'b1; check_all("R5 capture with clear held");
    clr_in[1] = 1'b0; cyc(2);
  endtask

  task automatic t_both_force();
    set_in[0] = 1'b1; cyc(3); exp_q[0] = 1'b1; set_in[0] = 1'b0; settle();
    check_all("R4 set before tie");
    set_in[0] = 1'b1; clr_in[0] = 1'b1; cyc(3); exp_q[0] = 1'b0;
    check_all("R8 clear wins tie");
    set_in[0] = 1'b0; clr_in[0] = 1'b0; settle();
  endtask

  task automatic t_force_vs_capture();
    d_in[2] = 1'b0; cyc(1);
    set_in[2] = 1'b1; cap_in[2] = 1'b1; cyc(3); exp_q[2] = 1'b1;
    check_all("R9 set beats capture");
    set_in[2] = 1'b0; cap_in[2] = 1'b0; settle();
    d_in[2] = 1'b1; cyc(1);
    clr_in[2] = 1'b1; cap_in[2] = 1'b1; cyc(3); exp_q[2] = 1'b0;
    check_all("R9 clear beats capture");
    clr_in[2] = 1'b0; cap_in[2] = 1'b0; settle();
  endtask

  task automatic t_window();
    d_in[0] = 1'b1; cyc(1);
    clr_in[0] = 1'b1; cyc(REC);
    cap_in[0] = 1'b1; cyc(3);
    check_all("R7 capture at last window cycle dropped");
    settle(); check_all("R7 dropped capture not deferred");
    clr_in[0] = 1'b0; cap_in[0] = 1'b0; settle();
    clr_in[0] = 1'b1; cyc(REC + 1);
    cap_in[0] = 1'b1; cyc(3); exp_q[0] = 1'b1;
    check_all("R7 capture just after window acts");
    clr_in[0] = 1'b0; cap_in[0] = 1'b0; settle();
    clr_in[0] = 1'b1; cyc(2);
    set_in[0] = 1'b1; cyc(3); exp_q[0] = 1'b0;
    check_all("R7 set inside window dropped");
    settle(); check_all("R7 set stays dropped");
    clr_in[0] = 1'b0; set_in[0] = 1'b0; settle();
  endtask

  task automatic t_reset_again();
    set_in = '1; cyc(3); exp_q = '1; check_all("R4 set all");
    set_in = '0; settle();
    rst = 1'b1; cyc(2); exp_q = '0; check_all("R10 reset clears outputs");
    rst = 1'b0; cyc(2);
    capture(1, 1'b1); exp_q[1] = 1'b1; check_all("R10 no window after reset");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    cyc(2);
    t_reset_state();
    t_capture();
    t_set_held();
    t_clear_held();
    t_both_force();
    t_force_vs_capture();
    t_window();
    t_reset_again();
    finish_run();
  end

  initial begin
    #(CLK_PERIOD * 20000);
    checks++; fails++;
    $display("FAIL watchdog: run did not complete");
    finish_run();
  end
endmodule